// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block runs the word-at-a-time sequential programming session of an SPI serial flash. It watches the byte stream that the command decoder hands over for each chip-select frame. The first word-program command of a session brings a 24-bit start address and two data bytes. Each later command brings only two data bytes. For every command the block issues two byte-write requests to the memory write port: the even byte of the current word first, then the odd byte. It then moves its internal word pointer on by two.

After each pair the block reports busy for a fixed programming time, set by a parameter counted in clock cycles. It also lets the host ask for a ready/busy level on the serial output between commands. The session ends on a write-disable or read-status opcode. When it ends, the block asks the decoder to clear the write-enable latch.

Top module: `aai_word_prog`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), mem_we, busy, aai_active, wel_clr and so_oe are all low.
- R2: A frame whose first byte is ADh starts a session if no session is active, wel is high and busy is low. The next three bytes form the start address, most significant byte first, and only the low AW bits are kept. The next two bytes are data. Two clock edges after the edge that accepts the last data byte, mem_we goes high for two cycles. The first cycle writes data byte 0 to the start address with bit 0 forced to 0. The second writes data byte 1 to the same address with bit 0 set to 1.
- R3: An ADh frame with wel low while no session is active produces no write and does not raise aai_active.
- R4: While a session is active, a frame of ADh plus two data bytes writes the next word: the previous even address plus 2, taken modulo 2^AW so that the pointer wraps at the top of the array.
- R5: busy rises in the cycle after the last data byte of a command is accepted. It stays high for exactly PROG_CYCLES+3 consecutive cycles.
- R6: An ADh opcode accepted while busy is high is ignored for the rest of its frame: no write results and the word pointer does not move.
- R7: While a session is active, opcode 04h or 05h ends it. wel_clr pulses high for one cycle after the opcode is accepted and aai_active falls. A later ADh frame needs wel again and is taken as a first command.
- R8: Any other opcode during a session is ignored, and aai_active stays high.
- R9: If cs_n goes high before the last data byte of a command, no write results and the word pointer does not move.
- R10: Opcode 70h turns the ready/busy indication on and 80h turns it off, whether or not a session is active. While it is on, aai_active and the frame's chip select are both active, and other_out is low, so_oe is high and so_dout is the inverse of busy.
- R11: so_oe is low whenever cs_n is high, other_out is high, the indication is off or no session is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, low for the whole frame; high resets frame parsing |
| rx_vld | input | 1 | One received byte is present this cycle |
| rx_byte | input | 8 | Received byte, the opcode being the first of a frame |
| wel | input | 1 | Write-enable latch state from the decoder |
| other_out | input | 1 | Another function is driving the serial output |
| mem_we | output | 1 | Byte write request to the memory port |
| mem_addr | output | AW | Byte address of the write request |
| mem_din | output | 8 | Byte to be written |
| busy | output | 1 | Command in progress or programming time running |
| aai_active | output | 1 | A word-program session is open |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| so_oe | output | 1 | Drive enable for the ready/busy level on the serial output |
| so_dout | output | 1 | Ready/busy level: high means ready |

## Verification
A word pointer that is wrong shows up as soon as the next command writes to memory. The mismatch appears at mem_addr two cycles after that command's last byte. The wrap and the forced-even start address show it at the first or third command. A session flag that is stuck or lost shows within one frame, either as an unexpected write or as a missing one. The same fault shows at once on aai_active, and on so_oe while chip select is low. A wrong busy counter shows as a pulse of the wrong length right after a command. It also shows when a command that arrives too early is accepted, which produces an unexpected write.

// File: rtl/aai_pkg.sv
// Package aai_pkg: opcodes and state encodings shared by the word
// program sequencer. Assumes an 8-bit command byte stream.
package aai_pkg;
    localparam logic [7:0] OP_WORD_PROG = 8'hAD;
    localparam logic [7:0] OP_IND_ON    = 8'h70;
    localparam logic [7:0] OP_IND_OFF   = 8'h80;
    localparam logic [7:0] OP_WR_DIS    = 8'h04;
    localparam logic [7:0] OP_RD_STAT   = 8'h05;

    // What the current frame is being parsed as
    typedef enum logic [1:0] {FR_SKIP, FR_START, FR_CONT} frame_kind_t;

    // Write pulse phase: idle, even byte, odd byte
    typedef enum logic [1:0] {PH_IDLE, PH_EVEN, PH_ODD} wr_phase_t;
endpackage

// File: rtl/aai_frame.sv
// Module aai_frame: parses one chip-select frame at a time. It decides
// from the opcode whether the frame opens a session, continues one, ends
// one or toggles the busy indication, and it captures the address and the
// two data bytes. It issues a one-cycle go pulse when a command is
// complete. Assumes 9 <= AW <= 24 and that cs_n goes high between frames.
module aai_frame
    import aai_pkg::*;
#(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rx_vld,
    input  logic [7:0]    rx_byte,
    input  logic          wel,
    input  logic          busy,
    output logic          go,
    output logic          go_first,
    output logic [AW-1:0] start_addr,
    output logic [7:0]    d0,
    output logic [7:0]    d1,
    output logic          session,
    output logic          wel_clr,
    output logic          ind_en
);
    logic [2:0]  bcnt;
    frame_kind_t kind;
    logic        take;
    logic        first_byte;

    assign take       = rx_vld && !cs_n;
    assign first_byte = take && (bcnt == 3'd0);

    // Byte position within the frame, saturating, cleared between frames
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n)
            bcnt <= 3'd0;
        else if (take && bcnt != 3'd7)
            bcnt <= bcnt + 3'd1;
    end

    // Frame classification taken from the opcode byte
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n)
            kind <= FR_SKIP;
        else if (first_byte) begin
            if (rx_byte == OP_WORD_PROG && !busy && (session || wel))
                kind <= session ? FR_CONT : FR_START;
            else
                kind <= FR_SKIP;
        end
    end

    // Capture the address and data bytes of an accepted command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr <= '0;
            d0         <= '0;
            d1         <= '0;
        end else if (take) begin
            if (kind == FR_START) begin
                if (bcnt >= 3'd1 && bcnt <= 3'd3)
                    start_addr <= {start_addr[AW-9:0], rx_byte};
                if (bcnt == 3'd4) d0 <= rx_byte;
                if (bcnt == 3'd5) d1 <= rx_byte;
            end else if (kind == FR_CONT) begin
                if (bcnt == 3'd1) d0 <= rx_byte;
                if (bcnt == 3'd2) d1 <= rx_byte;
            end
        end
    end

    // One-cycle command-complete pulse toward the writer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go       <= 1'b0;
            go_first <= 1'b0;
        end else begin
            go <= 1'b0;
            if (take && kind == FR_START && bcnt == 3'd5) begin
                go       <= 1'b1;
                go_first <= 1'b1;
            end else if (take && kind == FR_CONT && bcnt == 3'd2) begin
                go       <= 1'b1;
                go_first <= 1'b0;
            end
        end
    end

    // Session flag, latch-clear request and indication enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            session <= 1'b0;
            wel_clr <= 1'b0;
            ind_en  <= 1'b0;
        end else begin
            wel_clr <= 1'b0;
            if (first_byte) begin
                if (session && (rx_byte == OP_WR_DIS || rx_byte == OP_RD_STAT)) begin
                    session <= 1'b0;
                    wel_clr <= 1'b1;
                end
                if (rx_byte == OP_IND_ON)  ind_en <= 1'b1;
                if (rx_byte == OP_IND_OFF) ind_en <= 1'b0;
            end
            if (take && kind == FR_START && bcnt == 3'd5)
                session <= 1'b1;
        end
    end

    AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> !session);                                         // R7
    AST_GO_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> session);                                               // R4
endmodule

// File: rtl/aai_writer.sv
// Module aai_writer: turns a go pulse into two byte-write cycles (even
// byte, then odd byte), keeps the word pointer and times the programming
// delay. Assumes go only arrives while busy is low.
module aai_writer
    import aai_pkg::*;
#(
    parameter int AW          = 19,
    parameter int PROG_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          go_first,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    d0,
    input  logic [7:0]    d1,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_din,
    output logic          busy
);
    localparam int CW = $clog2(PROG_CYCLES + 2);

    wr_phase_t     phase;
    logic [AW-1:0] waddr;
    logic [CW-1:0] cnt;

    // Write phase sequencing and word pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            waddr <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (go) begin
                    if (go_first) waddr <= start_addr & ~AW'(1);
                    phase <= PH_EVEN;
                end
                PH_EVEN: phase <= PH_ODD;
                PH_ODD: begin
                    phase <= PH_IDLE;
                    waddr <= waddr + AW'(2);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Programming time counter started after the odd byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (phase == PH_ODD)
            cnt <= CW'(PROG_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign busy     = go || (phase != PH_IDLE) || (cnt != '0);
    assign mem_we   = (phase != PH_IDLE);
    assign mem_addr = (phase == PH_ODD) ? (waddr | AW'(1)) : waddr;
    assign mem_din  = (phase == PH_ODD) ? d1 : d0;

    AST_GO_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (phase == PH_IDLE));                                    // R6
    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_addr[0]) |=> (mem_we && mem_addr[0]));         // R2
endmodule

// File: rtl/aai_word_prog.sv
// Module aai_word_prog: top of the auto-increment word program sequencer.
// Joins the frame parser and the writer and forms the ready/busy drive
// for the serial output. Assumes the decoder supplies one byte per
// rx_vld and owns the write-enable latch.
module aai_word_prog
    import aai_pkg::*;
#(
    parameter int AW          = 19,
    parameter int PROG_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rx_vld,
    input  logic [7:0]    rx_byte,
    input  logic          wel,
    input  logic          other_out,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_din,
    output logic          busy,
    output logic          aai_active,
    output logic          wel_clr,
    output logic          so_oe,
    output logic          so_dout
);
    logic          go, go_first, ind_en;
    logic [AW-1:0] start_addr;
    logic [7:0]    d0, d1;

    aai_frame #(.AW(AW)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_vld(rx_vld),
        .rx_byte(rx_byte), .wel(wel), .busy(busy), .go(go),
        .go_first(go_first), .start_addr(start_addr), .d0(d0), .d1(d1),
        .session(aai_active), .wel_clr(wel_clr), .ind_en(ind_en)
    );

    aai_writer #(.AW(AW), .PROG_CYCLES(PROG_CYCLES)) u_writer (
        .clk(clk), .rst_n(rst_n), .go(go), .go_first(go_first),
        .start_addr(start_addr), .d0(d0), .d1(d1), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_din(mem_din), .busy(busy)
    );

    // Ready/busy level on the serial output between commands
    assign so_oe   = ind_en && aai_active && !cs_n && !other_out;
    assign so_dout = !busy;

    AST_START_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aai_active) |=> (mem_we && !mem_addr[0]));               // R2
endmodule

// File: tb/aai_word_prog_test.sv
module aai_word_prog_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int PROG = 5;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rx_vld = 1'b0;
    logic [7:0] rx_byte = '0;
    logic wel = 1'b0, other_out = 1'b0;
    logic mem_we, busy, aai_active, wel_clr, so_oe, so_dout;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_din;

    int checks = 0, fails = 0;
    logic [AW+7:0] expq[$];

    aai_word_prog #(.AW(AW), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_vld(rx_vld),
        .rx_byte(rx_byte), .wel(wel), .other_out(other_out),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_din(mem_din),
        .busy(busy), .aai_active(aai_active), .wel_clr(wel_clr),
        .so_oe(so_oe), .so_dout(so_dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_vld = 1'b1; rx_byte = b;
        @(negedge clk); rx_vld = 1'b0;
    endtask

    task automatic fbegin();
        @(negedge clk); cs_n = 1'b0;
    endtask

    task automatic fend();
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [AW-1:0] a, input logic [7:0] d);
        expq.push_back({a, d});
    endtask

    task automatic wait_ready();
        while (busy) @(negedge clk);
    endtask

    // Monitor: every write request must match the next expected item
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (expq.size() == 0)
                chk(1'b0, "R3/R6/R9 unexpected write", int'({mem_addr, mem_din}), 0);
            else begin
                logic [AW+7:0] e;
                e = expq.pop_front();
                chk({mem_addr, mem_din} == e, "R2/R4 write", int'({mem_addr, mem_din}), int'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!mem_we && !busy && !aai_active && !wel_clr && !so_oe, "R1 reset",
            int'({mem_we, busy, aai_active, wel_clr, so_oe}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: no write-enable, no session
        fbegin(); send(8'hAD); send(8'h12); send(8'h3F); send(8'hFD);
        send(8'h01); send(8'h02); fend();
        repeat (10) @(negedge clk);
        chk(!aai_active, "R3 session opened without wel", aai_active, 0);

        // R2/R5: first command, forced-even start address
        wel = 1'b1;
        push(12'hFFC, 8'hA1); push(12'hFFD, 8'hB2);
        fbegin(); send(8'hAD); send(8'h12); send(8'h3F); send(8'hFD);
        send(8'hA1); send(8'hB2);
        n = 0;
        while (busy && n < 50) begin n++; @(negedge clk); end
        chk(n == PROG + 3, "R5 busy length", n, PROG + 3);
        fend();
        chk(aai_active, "R2 session open", aai_active, 1);

        // R4 continuation, then R6 ignored while busy
        push(12'hFFE, 8'hC3); push(12'hFFF, 8'hD4);
        fbegin(); send(8'hAD); send(8'hC3); send(8'hD4); fend();
        fbegin(); send(8'hAD); send(8'hEE); send(8'hFF); fend();
        wait_ready();
        // R4 wrap at the top of the array
        push(12'h000, 8'h11); push(12'h001, 8'h22);
        fbegin(); send(8'hAD); send(8'h11); send(8'h22); fend();
        wait_ready();

        // R8: foreign opcode ignored in session
        fbegin(); send(8'h03); send(8'h00); send(8'h00); send(8'h00); fend();
        chk(aai_active, "R8 session kept", aai_active, 1);
        push(12'h002, 8'h33); push(12'h003, 8'h44);
        fbegin(); send(8'hAD); send(8'h33); send(8'h44); fend();
        wait_ready();

        // R9: aborted command, pointer unchanged
        fbegin(); send(8'hAD); send(8'h55); fend();
        repeat (10) @(negedge clk);
        push(12'h004, 8'h66); push(12'h005, 8'h77);
        fbegin(); send(8'hAD); send(8'h66); send(8'h77); fend();
        wait_ready();

        // R10/R11: ready/busy indication
        fbegin(); send(8'h70); fend();
        push(12'h006, 8'h88); push(12'h007, 8'h99);
        fbegin(); send(8'hAD); send(8'h88); send(8'h99);
        chk(so_oe && !so_dout, "R10 busy shown", int'({so_oe, so_dout}), 2);
        other_out = 1'b1; #1;
        chk(!so_oe, "R11 other output wins", so_oe, 0);
        other_out = 1'b0;
        wait_ready();
        chk(so_oe && so_dout, "R10 ready shown", int'({so_oe, so_dout}), 3);
        fend();
        chk(!so_oe, "R11 cs high", so_oe, 0);
        fbegin(); send(8'h80); fend();
        fbegin(); @(negedge clk);
        chk(!so_oe, "R10 indication off", so_oe, 0);
        fend();

        // R7: write-disable ends the session
        fbegin(); send(8'h04);
        chk(wel_clr, "R7 wel_clr pulse", wel_clr, 1);
        fend();
        chk(!aai_active && !wel_clr, "R7 session closed", int'({aai_active, wel_clr}), 0);
        wel = 1'b0;
        fbegin(); send(8'hAD); send(8'h12); send(8'h34); fend();
        repeat (10) @(negedge clk);
        wel = 1'b1;
        push(12'h010, 8'h5A); push(12'h011, 8'hA5);
        fbegin(); send(8'hAD); send(8'h00); send(8'h00); send(8'h10);
        send(8'h5A); send(8'hA5); fend();
        wait_ready();
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R2/R4 missing writes", expq.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule